// File: doc/BRIEF.md
# Multi-Cycle Read Transaction Responder

This block answers read transactions on a shared command and data bus. A host places a read instruction on a small command field, raises a command-valid strobe, and puts the address word on the data bus in the same cycle. The address word carries the device ID, a target selector and a location index. Every responder on the bus decodes the instruction. Only the one whose ID matches answers. An all-ones ID field is a broadcast, and it is answered only by the device marked as the last one on the chain.

The answering device leaves the bus alone for two turnaround cycles. It then drives the data bus for two cycles, with the read word in the second of them, and runs its acknowledge through low, high and low before it releases it. A burst read takes its start location and its beat count from an internal burst register. Each extra beat adds one drive/data cycle pair. The register steps forward after each beat. The data bus and acknowledge are brought out as separate value and enable outputs. Around the bus, the pad ring builds the tri-state drivers from these.

The block holds a small model of the storage it reads from: a data array, a mask array and a register bank. These are filled through a plain write port. The burst register has its own load port.

Top module: `rd_resp`

## Requirements
- R1: After reset the data-bus enable `dq_oe` and the acknowledge enable `ack_oe` are both 0, and the block is idle.
- R2: A selected single read accepted at the clock edge that ends cycle 1 behaves as follows. In cycles 2 and 3 both enables are 0. In cycle 4 `dq_oe`=1, `ack_oe`=1 and `ack_out`=0. In cycle 5 `dq_oe`=1, `ack_out`=1 and `dq_out` holds the addressed word. In cycle 6 `dq_oe`=0, `ack_oe`=1 and `ack_out`=0. In cycle 7 both enables are 0, and a new instruction may be presented in cycle 7.
- R3: The block is selected only when `dq_in[25:21]` equals `dev_id`. Any other value that is not all ones leaves both enables 0.
- R4: When `dq_in[25:21]` is 5'b11111 the block is selected if and only if `last_dev` is 1.
- R5: After a valid read that does not select it, the block keeps both enables at 0 for the rest of that transaction and ignores every instruction until it ends. The transaction ends 2n+3 cycles after cycle 1, where n is 1 for a single read and the burst-register count for a burst. The block accepts a new instruction in the cycle that follows.
- R6: The target is `dq_in[20:19]`: 00 selects the data array, 01 the mask array, and 1x the register bank. The location index is `dq_in[AW-1:0]`.
- R7: A selected burst (`cmd[2]`=1) of count n returns n beats. Each beat is one drive cycle (acknowledge low) followed by one data cycle (acknowledge high). Beat k returns the word at (start + k) mod 2^AW. A single low acknowledge cycle follows the last beat.
- R8: Each burst beat advances the burst start address by one and lowers the burst count by one. A burst therefore leaves the count at 0 and the address just past its last beat. A later burst continues from that address.
- R9: A burst aimed at the register bank is ignored, and so is a burst while the burst count is 0. Neither drives the bus or the acknowledge, and neither changes the burst register.
- R10: An instruction is a read only when `cmd_valid`=1 and `cmd[1:0]`=2'b00. With any other opcode, or with `cmd_valid`=0, the block does not respond.
- R11: `cfg_addr_we` loads the burst start address from `cfg_addr`, and `cfg_cnt_we` loads the burst count from `cfg_cnt`. The two fields load independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | [1:0] opcode (00 = read), [2] burst select |
| dq_in | input | DW | Data bus as seen by the block; address word in cycle 1 |
| dev_id | input | 5 | This device's ID |
| last_dev | input | 1 | Marks this device as the broadcast responder |
| cfg_addr_we | input | 1 | Load burst start address |
| cfg_cnt_we | input | 1 | Load burst count |
| cfg_addr | input | AW | Burst start address value |
| cfg_cnt | input | CW | Burst count value |
| mw_en | input | 1 | Storage model write enable |
| mw_tgt | input | 2 | Storage model write target (same coding as R6) |
| mw_addr | input | AW | Storage model write index |
| mw_data | input | DW | Storage model write word |
| dq_out | output | DW | Data bus drive value |
| dq_oe | output | 1 | Data bus drive enable |
| ack_out | output | 1 | Acknowledge drive value |
| ack_oe | output | 1 | Acknowledge drive enable |

## Verification
The bench uses the default widths: a 68-bit bus, AW=4 (16 locations per array) and CW=4 (bursts of up to 15 beats). With only 16 locations, a burst that starts near the top of an array wraps through index 0 within a few beats, so the address wrap can be checked directly. A count field this narrow also keeps the skip window of a non-selected burst short enough to be checked cycle by cycle.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_TA2, S_TA3, S_DRV, S_DAT, S_END, S_SKIP
  } seq_st_t;

  localparam logic [1:0] OP_READ = 2'b00;
  localparam int ID_LO  = 21;
  localparam int ID_W   = 5;
  localparam int TGT_LO = 19;

  // Selection rule: exact ID match, or all-ones broadcast taken by the last device.
  function automatic logic id_selects(input logic [ID_W-1:0] own,
                                      input logic [ID_W-1:0] field,
                                      input logic            last);
    if (field == {ID_W{1'b1}}) return last;
    return field == own;
  endfunction

  // Register-class targets are 2'b1x.
  function automatic logic is_reg_tgt(input logic [1:0] t);
    return t[1];
  endfunction

  // Storage bank picked by a target code: 0 data, 1 mask, 2 registers.
  function automatic logic [1:0] bank_of(input logic [1:0] t);
    if (t[1]) return 2'd2;
    return {1'b0, t[0]};
  endfunction

  // Cycles a device stays busy after cycle 1 for a transaction of n beats.
  function automatic int unsigned hold_span(input int unsigned n);
    return 2 * n + 3;
  endfunction

endpackage

// File: rtl/rdr_decode.sv
module rdr_decode
  import rdr_pkg::*;
#(
  parameter int DW = 68,
  parameter int AW = 4,
  parameter int CW = 4
) (
  input  logic          cmd_valid,
  input  logic [2:0]    cmd,
  input  logic [DW-1:0] dq_in,
  input  logic [4:0]    dev_id,
  input  logic          last_dev,
  input  logic [CW-1:0] burst_cnt,
  output logic          go_sel,
  output logic          go_skip,
  output logic          req_burst,
  output logic [1:0]    req_tgt,
  output logic [AW-1:0] req_idx,
  output logic [CW-1:0] req_beats
);

  logic          is_read;
  logic          refused;
  logic          hit;
  logic [4:0]    id_field;
  logic          unused_dq;

  assign id_field  = dq_in[ID_LO +: ID_W];
  assign req_tgt   = dq_in[TGT_LO +: 2];
  assign req_idx   = dq_in[AW-1:0];
  assign req_burst = cmd[2];
  assign unused_dq = ^{dq_in[DW-1:ID_LO+ID_W], dq_in[TGT_LO-1:AW]};

  assign is_read   = cmd_valid && (cmd[1:0] == OP_READ);
  assign refused   = req_burst && (is_reg_tgt(req_tgt) || (burst_cnt == '0));
  assign hit       = id_selects(dev_id, id_field, last_dev);

  assign go_sel    = is_read && !refused && hit;
  assign go_skip   = is_read && !refused && !hit;
  assign req_beats = req_burst ? burst_cnt : CW'(1);

endmodule

// File: rtl/rdr_burst.sv
module rdr_burst #(
  parameter int AW = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] ld_addr_val,
  input  logic [CW-1:0] ld_cnt_val,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
    end else begin
      if (step) cur_addr <= cur_addr + AW'(1);
      else if (ld_addr) cur_addr <= ld_addr_val;
      if (step) cur_cnt <= (cur_cnt == '0) ? '0 : cur_cnt - CW'(1);
      else if (ld_cnt) cur_cnt <= ld_cnt_val;
    end
  end

endmodule

// File: rtl/rdr_store.sv
module rdr_store
  import rdr_pkg::*;
#(
  parameter int DW = 68,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [1:0]    wr_tgt,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_tgt,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;
  localparam int NBANK = 3;

  logic [1:0]    wr_bank;
  logic [1:0]    rd_bank;
  logic [DW-1:0] bank_q [NBANK];

  assign wr_bank = bank_of(wr_tgt);
  assign rd_bank = bank_of(rd_tgt);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 2'(b))) mem[wr_addr] <= wr_data;
    end
    assign bank_q[b] = mem[rd_addr];
  end

  always_comb begin
    case (rd_bank)
      2'd0:    rd_data = bank_q[0];
      2'd1:    rd_data = bank_q[1];
      default: rd_data = bank_q[2];
    endcase
  end

endmodule

// File: rtl/rdr_seq.sv
module rdr_seq
  import rdr_pkg::*;
#(
  parameter int AW = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_sel,
  input  logic          go_skip,
  input  logic          req_burst,
  input  logic [1:0]    req_tgt,
  input  logic [AW-1:0] req_idx,
  input  logic [CW-1:0] req_beats,
  output logic          dq_oe,
  output logic          ack_oe,
  output logic          ack_out,
  output logic          data_phase,
  output logic          beat_done,
  output logic          start_sel,
  output logic          skipping,
  output logic          lat_burst,
  output logic [1:0]    lat_tgt,
  output logic [AW-1:0] lat_idx
);

  localparam int SW = CW + 2;

  seq_st_t       st;
  logic [CW-1:0] rem;
  logic [SW-1:0] skip_cnt;
  logic          idle;

  assign idle      = (st == S_IDLE);
  assign start_sel = idle && go_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rem       <= '0;
      skip_cnt  <= '0;
      lat_burst <= 1'b0;
      lat_tgt   <= '0;
      lat_idx   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (go_sel) begin
            st        <= S_TA2;
            rem       <= req_beats;
            lat_burst <= req_burst;
            lat_tgt   <= req_tgt;
            lat_idx   <= req_idx;
          end else if (go_skip) begin
            st       <= S_SKIP;
            skip_cnt <= SW'(hold_span(32'(req_beats)));
          end
        end
        S_TA2: st <= S_TA3;
        S_TA3: st <= S_DRV;
        S_DRV: st <= S_DAT;
        S_DAT: begin
          if (rem == CW'(1)) st <= S_END;
          else begin
            rem <= rem - CW'(1);
            st  <= S_DRV;
          end
        end
        S_END: st <= S_IDLE;
        S_SKIP: begin
          if (skip_cnt == SW'(1)) st <= S_IDLE;
          else skip_cnt <= skip_cnt - SW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign data_phase = (st == S_DAT);
  assign dq_oe      = (st == S_DRV) || (st == S_DAT);
  assign ack_oe     = dq_oe || (st == S_END);
  assign ack_out    = data_phase;
  assign beat_done  = data_phase && lat_burst;
  assign skipping   = (st == S_SKIP);

endmodule

// File: rtl/rd_resp.sv
module rd_resp #(
  parameter int DW = 68,
  parameter int AW = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd,
  input  logic [DW-1:0] dq_in,
  input  logic [4:0]    dev_id,
  input  logic          last_dev,
  input  logic          cfg_addr_we,
  input  logic          cfg_cnt_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          mw_en,
  input  logic [1:0]    mw_tgt,
  input  logic [AW-1:0] mw_addr,
  input  logic [DW-1:0] mw_data,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          ack_out,
  output logic          ack_oe
);

  logic          go_sel, go_skip, req_burst;
  logic [1:0]    req_tgt;
  logic [AW-1:0] req_idx;
  logic [CW-1:0] req_beats;
  logic [AW-1:0] burst_addr;
  logic [CW-1:0] burst_cnt;
  logic          data_phase, beat_done, start_sel, skipping;
  logic          lat_burst;
  logic [1:0]    lat_tgt;
  logic [AW-1:0] lat_idx;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  rdr_decode #(.DW(DW), .AW(AW), .CW(CW)) u_dec (
    .cmd_valid(cmd_valid), .cmd(cmd), .dq_in(dq_in), .dev_id(dev_id),
    .last_dev(last_dev), .burst_cnt(burst_cnt), .go_sel(go_sel),
    .go_skip(go_skip), .req_burst(req_burst), .req_tgt(req_tgt),
    .req_idx(req_idx), .req_beats(req_beats)
  );

  rdr_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_sel(go_sel), .go_skip(go_skip),
    .req_burst(req_burst), .req_tgt(req_tgt), .req_idx(req_idx),
    .req_beats(req_beats), .dq_oe(dq_oe), .ack_oe(ack_oe),
    .ack_out(ack_out), .data_phase(data_phase), .beat_done(beat_done),
    .start_sel(start_sel), .skipping(skipping), .lat_burst(lat_burst),
    .lat_tgt(lat_tgt), .lat_idx(lat_idx)
  );

  rdr_burst #(.AW(AW), .CW(CW)) u_bur (
    .clk(clk), .rst_n(rst_n), .ld_addr(cfg_addr_we), .ld_cnt(cfg_cnt_we),
    .ld_addr_val(cfg_addr), .ld_cnt_val(cfg_cnt), .step(beat_done),
    .cur_addr(burst_addr), .cur_cnt(burst_cnt)
  );

  assign rd_addr = lat_burst ? burst_addr : lat_idx;

  rdr_store #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .wr_en(mw_en), .wr_tgt(mw_tgt), .wr_addr(mw_addr),
    .wr_data(mw_data), .rd_tgt(lat_tgt), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  assign dq_out = data_phase ? rd_data : '0;

endmodule

// File: rtl/rdr_chk.sv
module rdr_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dq_oe,
  input logic          ack_oe,
  input logic          ack_out,
  input logic          start_sel,
  input logic          skipping,
  input logic          beat_done,
  input logic [CW-1:0] burst_cnt
);

  p_data_under_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ack_oe);

  p_ack_opens_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe) |-> !ack_out);

  p_ack_high_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |=> (ack_oe && !ack_out));

  p_turnaround_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_sel |=> (!dq_oe && !ack_oe) ##1 (!dq_oe && !ack_oe)
                  ##1 (dq_oe && ack_oe && !ack_out));

  p_release_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_oe) |-> (!$past(ack_out) && !$past(dq_oe)));

  p_skip_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    skipping |-> (!dq_oe && !ack_oe));

  p_step_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |=> (burst_cnt == $past(burst_cnt) - CW'(1)));

  p_beat_on_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |-> (dq_oe && ack_out));

endmodule

bind rd_resp rdr_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dq_oe(dq_oe), .ack_oe(ack_oe),
  .ack_out(ack_out), .start_sel(start_sel), .skipping(skipping),
  .beat_done(beat_done), .burst_cnt(burst_cnt)
);

// File: tb/rd_resp_test.sv
module rd_resp_test;
  localparam int DW = 68;
  localparam int AW = 4;
  localparam int CW = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [4:0] OWN = 5'd9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd = '0;
  logic [DW-1:0] dq_in = '0;
  logic [4:0]    dev_id = OWN;
  logic          last_dev = 1'b0;
  logic          cfg_addr_we = 1'b0, cfg_cnt_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_cnt = '0;
  logic          mw_en = 1'b0;
  logic [1:0]    mw_tgt = '0;
  logic [AW-1:0] mw_addr = '0;
  logic [DW-1:0] mw_data = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe, ack_out, ack_oe;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] shadow [3][DEPTH];
  int b_addr = 0, b_cnt = 0;

  always #5 clk = ~clk;

  rd_resp #(.DW(DW), .AW(AW), .CW(CW)) uut (.*);

  function automatic int bank(input logic [1:0] t);
    return t[1] ? 2 : int'(t[0]);
  endfunction

  function automatic logic [DW-1:0] want(input logic [1:0] t, input int a);
    return shadow[bank(t)][a % DEPTH];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet(input string req, input int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      chk(!dq_oe && !ack_oe, req, {dq_oe, ack_oe}, '0);
      @(negedge clk);
    end
  endtask

  // Drive one instruction during cycle 1; returns in the middle of cycle 2.
  task automatic issue(input logic valid, input logic [2:0] c, input logic [4:0] idf,
                       input logic [1:0] tg, input logic [AW-1:0] ix);
    cmd_valid = valid;
    cmd = c;
    dq_in = '0;
    dq_in[25:21] = idf;
    dq_in[20:19] = tg;
    dq_in[AW-1:0] = ix;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd = 3'b111;
    dq_in = '0;
  endtask

  // Checks cycles 2..end of a selected read; returns in the middle of the next free cycle.
  task automatic expect_read(input string req, input logic [1:0] tg, input int base,
                             input int beats);
    for (int t = 0; t < 2; t++) begin
      chk(!dq_oe && !ack_oe, {req, " turnaround"}, {dq_oe, ack_oe}, '0);
      @(negedge clk);
    end
    for (int k = 0; k < beats; k++) begin
      chk(dq_oe && ack_oe && !ack_out, {req, " drive"}, {dq_oe, ack_oe, ack_out}, 3'b110);
      @(negedge clk);
      chk(dq_oe && ack_oe && ack_out && dq_out == want(tg, base + k), {req, " data"},
          dq_out, want(tg, base + k));
      @(negedge clk);
    end
    chk(!dq_oe && ack_oe && !ack_out, {req, " tail"}, {dq_oe, ack_oe, ack_out}, 3'b010);
    @(negedge clk);
    chk(!dq_oe && !ack_oe, {req, " release"}, {dq_oe, ack_oe}, '0);
  endtask

  task automatic run_burst(input string req, input logic [1:0] tg);
    int n = b_cnt;
    issue(1'b1, 3'b100, OWN, tg, '0);
    expect_read(req, tg, b_addr, n);
    b_addr = (b_addr + n) % DEPTH;
    b_cnt = 0;
  endtask

  task automatic load_burst(input bit la, input int a, input bit lc, input int c);
    cfg_addr_we = la; cfg_addr = AW'(a);
    cfg_cnt_we = lc;  cfg_cnt = CW'(c);
    @(negedge clk);
    cfg_addr_we = 1'b0; cfg_cnt_we = 1'b0;
    if (la) b_addr = a;
    if (lc) b_cnt = c;
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!dq_oe && !ack_oe, "R1 reset", {dq_oe, ack_oe}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dq_oe && !ack_oe, "R1 idle", {dq_oe, ack_oe}, '0);

    for (int b = 0; b < 3; b++)
      for (int a = 0; a < DEPTH; a++) begin
        logic [DW-1:0] w;
        w = {$urandom, $urandom, $urandom};
        shadow[b][a] = w;
        mw_en = 1'b1; mw_tgt = (b == 2) ? 2'b10 : 2'(b); mw_addr = AW'(a); mw_data = w;
        @(negedge clk);
      end
    mw_en = 1'b0;

    // R2/R6: directed singles, issued back to back in cycle 7
    issue(1'b1, 3'b000, OWN, 2'b00, 4'd0);  expect_read("R2 R6 data", 2'b00, 0, 1);
    issue(1'b1, 3'b000, OWN, 2'b01, 4'd15); expect_read("R6 mask", 2'b01, 15, 1);
    issue(1'b1, 3'b000, OWN, 2'b10, 4'd3);  expect_read("R6 reg", 2'b10, 3, 1);
    issue(1'b1, 3'b000, OWN, 2'b11, 4'd7);  expect_read("R6 reg alt", 2'b11, 7, 1);

    // R3: other ID, then R5 instruction during skip is ignored
    issue(1'b1, 3'b000, 5'd10, 2'b00, 4'd1); quiet("R3 mismatch", 6);
    issue(1'b1, 3'b000, 5'd10, 2'b00, 4'd1);
    issue(1'b1, 3'b000, OWN, 2'b00, 4'd2);  quiet("R5 ignored during skip", 8);
    issue(1'b1, 3'b000, OWN, 2'b00, 4'd2);  expect_read("R5 after skip", 2'b00, 2, 1);

    // R4: broadcast
    issue(1'b1, 3'b000, 5'h1F, 2'b00, 4'd4); quiet("R4 not last", 6);
    last_dev = 1'b1;
    issue(1'b1, 3'b000, 5'h1F, 2'b01, 4'd4); expect_read("R4 last", 2'b01, 4, 1);
    last_dev = 1'b0;

    // R10: non-read opcode and missing strobe
    issue(1'b1, 3'b001, OWN, 2'b00, 4'd5); quiet("R10 opcode", 6);
    issue(1'b0, 3'b000, OWN, 2'b00, 4'd5); quiet("R10 no strobe", 6);

    // R7/R11: burst wrapping past the top
    load_burst(1, 14, 1, 4);
    run_burst("R7 R11 wrap burst", 2'b00);
    // R9: zero count refused
    issue(1'b1, 3'b100, OWN, 2'b00, '0); quiet("R9 zero count", 6);
    // R8: continuation after separate count load
    load_burst(1, 5, 1, 2);
    run_burst("R8 first", 2'b01);
    load_burst(0, 0, 1, 3);
    run_burst("R8 continue", 2'b01);
    // R9: register-target burst refused, register untouched
    load_burst(0, 0, 1, 2);
    issue(1'b1, 3'b100, OWN, 2'b10, '0); quiet("R9 reg burst", 6);
    run_burst("R9 register unchanged", 2'b00);
    // R5: non-selected burst skips 2n+3 cycles
    load_burst(1, 3, 1, 3);
    issue(1'b1, 3'b100, 5'd2, 2'b00, '0); quiet("R5 burst skip", 9);
    issue(1'b1, 3'b000, OWN, 2'b00, 4'd8); expect_read("R5 burst skip end", 2'b00, 8, 1);

    // random singles
    for (int r = 0; r < 24; r++) begin
      logic [1:0] tg;
      logic [AW-1:0] ix;
      logic [4:0] idf;
      tg = 2'($urandom_range(0, 3));
      ix = AW'($urandom_range(0, DEPTH - 1));
      idf = ($urandom_range(0, 1) == 1) ? OWN : 5'($urandom_range(10, 30));
      issue(1'b1, 3'b000, idf, tg, ix);
      if (idf == OWN) expect_read("R2 R3 random", tg, int'(ix), 1);
      else quiet("R3 random other", 6);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule